// File: doc/BRIEF.md
# Legacy expansion-bus I/O cycle sequencer

This block runs I/O read and write cycles on a legacy PC-style expansion bus on behalf of a host. The host posts one request at a time. A request carries an address, a direction flag, a width flag (byte or 16-bit word) and write data. The block moves the request into the bus clock domain and drives the address, a byte-high-enable and the active-low read or write strobe. It drives the data lanes during writes and samples the slave's ready and 16-bit-capable lines. When the cycle is over, it hands a done pulse, the read data and an error flag back to the host clock domain.

Timing follows the bus conventions. An unstretched byte cycle takes 6 bus clocks and an unstretched word cycle takes 3, each counted from address setup to the end of the hold clock. A slave stretches the cycle by holding ready low. A word request becomes a single 16-bit cycle only when the slave reports that it can take 16 bits. Otherwise the block runs two byte cycles. The low byte goes first, the high byte moves over the low lanes, and the two read bytes are joined again. A cycle whose ready stays low too long is ended and flagged.

Top module: `isa_io_seq`

## Requirements
- R1: A byte cycle drives the address for 1 bus clock with both strobes high (setup), then holds one strobe low for CYC8-2 = 4 bus clocks, then holds the address for 1 more clock with strobes high. Write data goes on lanes [7:0].
- R2: A word request to a slave that holds cs16_ni low during setup makes one cycle with a strobe of CYC16-2 = 1 bus clock, all 16 lanes used, and bhe_no low. Read data returns as data_i[15:0].
- R3: Ready (chrdy_i, high = ready) is sampled at the last base strobe clock and at each clock after it. If the slave holds chrdy_i low for L clocks starting at strobe assertion, the strobe lasts max(base, L+1) clocks.
- R4: A word request to a slave with cs16_ni high makes two byte cycles. The first is at the request address with bhe_no low and byte 0. The second is at address+1 with bhe_no high and byte 1 on lanes [7:0]. Read bytes from data_i[7:0] are merged as {second, first}.
- R5: A byte request always makes exactly one byte cycle with bhe_no high, whatever cs16_ni says. Read data is {8'h00, data_i[7:0]}, and data_i[15:8] is ignored.
- R6: If chrdy_i is sampled low at more than TMO_LIM = 1024 consecutive end-of-command checks, the strobe is released after base+TMO_LIM clocks. The request then completes with err_o = 1, and any pending second byte cycle is skipped. Otherwise err_o = 0.
- R7: data_oe_o is high from setup to hold of write cycles only. It is low during read cycles and while idle.
- R8: ior_no and iow_no are never low together. io_addr_o is stable from one clock before a strobe falls until one clock after it rises, and changes only when both strobes are high.
- R9: req_ready_o is high only while no request is in flight. Exactly one single-clock done_o pulse follows each accepted request, and req_ready_o is high with it. Requests offered while req_ready_o is low cause no bus cycle.
- R10: While rst_ni is low, both strobes are high, data_oe_o is low, req_ready_o is high and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk_i | input | 1 | Host clock |
| bus_clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| req_valid_i | input | 1 | Host request strobe |
| req_ready_o | output | 1 | Block idle, request accepted when valid |
| req_addr_i | input | ADDR_W | I/O address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 16-bit request, 0 = byte |
| req_wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-clock completion pulse (host clock) |
| rdata_o | output | 16 | Read data, valid with done_o |
| err_o | output | 1 | Ready timeout, valid with done_o |
| io_addr_o | output | ADDR_W | Bus address |
| ior_no | output | 1 | Read strobe, active low |
| iow_no | output | 1 | Write strobe, active low |
| bhe_no | output | 1 | High byte enable, active low |
| bus_data_o | output | 16 | Write data lanes |
| data_oe_o | output | 1 | Data lane drive enable |
| data_i | input | 16 | Read data lanes |
| chrdy_i | input | 1 | Slave ready, low inserts wait clocks |
| cs16_ni | input | 1 | Slave 16-bit capable, active low |

## Verification
The bench's slave model holds ready low for a chosen number of clocks. That number is swept across the point where the last base strobe clock is sampled. A design that samples ready too early would stretch cycles that should stay short, and one that samples it late would lose a wait clock. Ready is also held low right at the timeout edge and one clock past it, on byte, word and split requests. A wrong limit would flag a cycle it should finish, and a missing abort path would still run the second byte of a split. Word requests go to byte-only slaves that put junk on the upper lanes. A design that fails to swap or merge would return that junk or send the wrong byte to address+1. Requests offered while busy must not start a cycle.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;
  localparam int unsigned BUS_DW = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_SETUP,
    BS_CMD,
    BS_HOLD
  } bus_state_e;

  typedef struct packed {
    logic [BUS_DW-1:0] data;
    logic              err;
  } io_rsp_t;
endpackage

// File: rtl/isa_io_sync.sv
module isa_io_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q[0] <= 1'b0;
    else         ff_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[g] <= 1'b0;
      else         ff_q[g] <= ff_q[g-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/isa_io_host_if.sv
module isa_io_host_if
  import isa_io_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_wide_i,
  input  logic [BUS_DW-1:0] req_wdata_i,
  output logic [ADDR_W-1:0] hold_addr_o,
  output logic              hold_write_o,
  output logic              hold_wide_o,
  output logic [BUS_DW-1:0] hold_wdata_o,
  output logic              req_tgl_o,
  input  logic              ack_tgl_i,
  input  io_rsp_t           rsp_i,
  output logic              done_o,
  output logic [BUS_DW-1:0] rdata_o,
  output logic              err_o
);
  logic busy_q, ack_seen_q;
  logic accept, ack_edge;

  assign accept      = req_valid_i & ~busy_q;
  assign ack_edge    = ack_tgl_i ^ ack_seen_q;
  assign req_ready_o = ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      ack_seen_q   <= 1'b0;
      req_tgl_o    <= 1'b0;
      hold_addr_o  <= '0;
      hold_write_o <= 1'b0;
      hold_wide_o  <= 1'b0;
      hold_wdata_o <= '0;
      done_o       <= 1'b0;
      rdata_o      <= '0;
      err_o        <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        // operands stay frozen while busy; the bus side reads them after the toggle
        hold_addr_o  <= req_addr_i;
        hold_write_o <= req_write_i;
        hold_wide_o  <= req_wide_i;
        hold_wdata_o <= req_wdata_i;
        req_tgl_o    <= ~req_tgl_o;
        busy_q       <= 1'b1;
      end else if (ack_edge) begin
        ack_seen_q <= ack_tgl_i;
        busy_q     <= 1'b0;
        done_o     <= 1'b1;
        rdata_o    <= rsp_i.data;
        err_o      <= rsp_i.err;
      end
    end
  end
endmodule

// File: rtl/isa_io_bus_fsm.sv
module isa_io_bus_fsm
  import isa_io_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned CYC8    = 6,
  parameter int unsigned CYC16   = 3,
  parameter int unsigned TMO_LIM = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  logic [ADDR_W-1:0] hold_addr_i,
  input  logic              hold_write_i,
  input  logic              hold_wide_i,
  input  logic [BUS_DW-1:0] hold_wdata_i,
  output logic              ack_tgl_o,
  output io_rsp_t           rsp_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic              ior_no,
  output logic              iow_no,
  output logic              bhe_no,
  output logic [BUS_DW-1:0] bus_data_o,
  output logic              data_oe_o,
  input  logic [BUS_DW-1:0] data_i,
  input  logic              chrdy_i,
  input  logic              cs16_ni
);
  localparam int unsigned CMD8    = CYC8 - 2;
  localparam int unsigned CMD16   = CYC16 - 2;
  localparam int unsigned CMD_MAX = (CMD8 > CMD16) ? CMD8 : CMD16;
  localparam int unsigned CNT_W   = $clog2(CMD_MAX + 1);
  localparam int unsigned TMO_W   = $clog2(TMO_LIM + 1);

  bus_state_e        state_q;
  logic              req_seen_q;
  logic [ADDR_W-1:0] base_addr_q;
  logic              wr_q, wide_q, is16_q, part_hi_q;
  logic [BUS_DW-1:0] wdata_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TMO_W-1:0]  wcnt_q;
  logic              active;
  logic              use16;

  assign active = (state_q != BS_IDLE);
  assign use16  = hold_wide_i & ~part_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= BS_IDLE;
      req_seen_q  <= 1'b0;
      ack_tgl_o   <= 1'b0;
      base_addr_q <= '0;
      io_addr_o   <= '0;
      wr_q        <= 1'b0;
      wide_q      <= 1'b0;
      is16_q      <= 1'b0;
      part_hi_q   <= 1'b0;
      wdata_q     <= '0;
      cnt_q       <= '0;
      wcnt_q      <= '0;
      rsp_o       <= '0;
    end else begin
      unique case (state_q)
        BS_IDLE: begin
          if (req_tgl_i != req_seen_q) begin
            req_seen_q  <= req_tgl_i;
            base_addr_q <= hold_addr_i;
            io_addr_o   <= hold_addr_i;
            wr_q        <= hold_write_i;
            wide_q      <= hold_wide_i;
            wdata_q     <= hold_wdata_i;
            part_hi_q   <= 1'b0;
            rsp_o       <= '0;
            state_q     <= BS_SETUP;
          end
        end
        BS_SETUP: begin
          // slave width is decoded from the address driven during setup
          is16_q  <= wide_q & ~cs16_ni & ~part_hi_q;
          cnt_q   <= (wide_q & ~cs16_ni & ~part_hi_q) ? CNT_W'(CMD16 - 1)
                                                       : CNT_W'(CMD8 - 1);
          wcnt_q  <= '0;
          state_q <= BS_CMD;
        end
        BS_CMD: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (chrdy_i) begin
            if (!wr_q) begin
              if (is16_q)         rsp_o.data             <= data_i;
              else if (part_hi_q) rsp_o.data[15:BYTE_W]  <= data_i[BYTE_W-1:0];
              else                rsp_o.data[BYTE_W-1:0] <= data_i[BYTE_W-1:0];
            end
            state_q <= BS_HOLD;
          end else if (wcnt_q == TMO_W'(TMO_LIM)) begin
            rsp_o.err <= 1'b1;
            state_q   <= BS_HOLD;
          end else begin
            wcnt_q <= wcnt_q + TMO_W'(1);
          end
        end
        BS_HOLD: begin
          if (!rsp_o.err && wide_q && !is16_q && !part_hi_q) begin
            part_hi_q <= 1'b1;
            io_addr_o <= base_addr_q + ADDR_W'(1);
            state_q   <= BS_SETUP;
          end else begin
            ack_tgl_o <= ~ack_tgl_o;
            state_q   <= BS_IDLE;
          end
        end
        default: state_q <= BS_IDLE;
      endcase
    end
  end

  assign ior_no    = ~((state_q == BS_CMD) & ~wr_q);
  assign iow_no    = ~((state_q == BS_CMD) &  wr_q);
  assign bhe_no    = ~(active & wide_q & ~part_hi_q);
  assign data_oe_o = active & wr_q;

  always_comb begin
    if (part_hi_q)   bus_data_o = {{BYTE_W{1'b0}}, wdata_q[15:BYTE_W]};
    else if (wide_q) bus_data_o = wdata_q;
    else             bus_data_o = {{BYTE_W{1'b0}}, wdata_q[BYTE_W-1:0]};
  end

  logic unused_use16;
  assign unused_use16 = use16;
endmodule

// File: rtl/isa_io_seq.sv
module isa_io_seq
  import isa_io_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CYC8      = 6,
  parameter int unsigned CYC16     = 3,
  parameter int unsigned TMO_LIM   = 1024,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              hclk_i,
  input  logic              bus_clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_wide_i,
  input  logic [15:0]       req_wdata_i,
  output logic              done_o,
  output logic [15:0]       rdata_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic              ior_no,
  output logic              iow_no,
  output logic              bhe_no,
  output logic [15:0]       bus_data_o,
  output logic              data_oe_o,
  input  logic [15:0]       data_i,
  input  logic              chrdy_i,
  input  logic              cs16_ni
);
  logic              req_tgl_h, req_tgl_b;
  logic              ack_tgl_b, ack_tgl_h;
  logic [ADDR_W-1:0] hold_addr;
  logic              hold_write, hold_wide;
  logic [BUS_DW-1:0] hold_wdata;
  io_rsp_t           rsp_b;

  isa_io_host_if #(.ADDR_W(ADDR_W)) u_host (
    .clk_i       (hclk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_write_i (req_write_i),
    .req_wide_i  (req_wide_i),
    .req_wdata_i (req_wdata_i),
    .hold_addr_o (hold_addr),
    .hold_write_o(hold_write),
    .hold_wide_o (hold_wide),
    .hold_wdata_o(hold_wdata),
    .req_tgl_o   (req_tgl_h),
    .ack_tgl_i   (ack_tgl_h),
    .rsp_i       (rsp_b),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .err_o       (err_o)
  );

  isa_io_sync #(.STAGES(SYNC_STGS)) u_sync_req (
    .clk_i (bus_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tgl_h),
    .q_o   (req_tgl_b)
  );

  isa_io_sync #(.STAGES(SYNC_STGS)) u_sync_ack (
    .clk_i (hclk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tgl_b),
    .q_o   (ack_tgl_h)
  );

  isa_io_bus_fsm #(
    .ADDR_W (ADDR_W),
    .CYC8   (CYC8),
    .CYC16  (CYC16),
    .TMO_LIM(TMO_LIM)
  ) u_bus (
    .clk_i       (bus_clk_i),
    .rst_ni      (rst_ni),
    .req_tgl_i   (req_tgl_b),
    .hold_addr_i (hold_addr),
    .hold_write_i(hold_write),
    .hold_wide_i (hold_wide),
    .hold_wdata_i(hold_wdata),
    .ack_tgl_o   (ack_tgl_b),
    .rsp_o       (rsp_b),
    .io_addr_o   (io_addr_o),
    .ior_no      (ior_no),
    .iow_no      (iow_no),
    .bhe_no      (bhe_no),
    .bus_data_o  (bus_data_o),
    .data_oe_o   (data_oe_o),
    .data_i      (data_i),
    .chrdy_i     (chrdy_i),
    .cs16_ni     (cs16_ni)
  );
endmodule

// File: rtl/isa_io_seq_chk.sv
module isa_io_seq_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned CYC8    = 6,
  parameter int unsigned CYC16   = 3,
  parameter int unsigned TMO_LIM = 1024
) (
  input logic              hclk_i,
  input logic              bus_clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] io_addr_o,
  input logic              ior_no,
  input logic              iow_no,
  input logic [15:0]       bus_data_o,
  input logic              data_oe_o
);
  localparam int unsigned CMD_MAX = (CYC8 > CYC16) ? CYC8 - 2 : CYC16 - 2;
  localparam int unsigned STB_MAX = CMD_MAX + TMO_LIM;
  localparam int unsigned STB_W   = $clog2(STB_MAX + 2);

  logic [STB_W-1:0] stb_cnt_q;
  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni)                stb_cnt_q <= '0;
    else if (!ior_no || !iow_no) stb_cnt_q <= stb_cnt_q + STB_W'(1);
    else                        stb_cnt_q <= '0;
  end

  a_r8_strobe_excl: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    !(!ior_no && !iow_no));

  a_r8_addr_setup: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    ($fell(ior_no) || $fell(iow_no)) |-> $stable(io_addr_o));

  a_r8_addr_hold: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    !$stable(io_addr_o) |-> (ior_no && iow_no && $past(ior_no && iow_no)));

  a_r7_oe_read: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    !ior_no |-> !data_oe_o);

  a_r7_oe_write: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    !iow_no |-> data_oe_o);

  a_r1_wdata_stable: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (!iow_no && $past(!iow_no)) |-> $stable(bus_data_o));

  a_r6_strobe_bound: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    stb_cnt_q <= STB_W'(STB_MAX));

  a_r9_done_pulse: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);
endmodule

bind isa_io_seq isa_io_seq_chk #(
  .ADDR_W (ADDR_W),
  .CYC8   (CYC8),
  .CYC16  (CYC16),
  .TMO_LIM(TMO_LIM)
) u_chk (
  .hclk_i     (hclk_i),
  .bus_clk_i  (bus_clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .done_o     (done_o),
  .io_addr_o  (io_addr_o),
  .ior_no     (ior_no),
  .iow_no     (iow_no),
  .bus_data_o (bus_data_o),
  .data_oe_o  (data_oe_o)
);

// File: tb/isa_io_seq_test.sv
module isa_io_seq_test;
  localparam int HCLK_PERIOD = 10;
  localparam int BUS_PERIOD  = 26;
  localparam int TMO         = 1024;
  localparam int CMD8        = 4;
  localparam int CMD16       = 1;

  logic        hclk = 0, bus_clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_wide = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic        req_ready, done, err;
  logic [15:0] rdata, io_addr, bus_data, data_in;
  logic        ior_n, iow_n, bhe_n, data_oe;
  logic        chrdy = 1;
  logic        slave16 = 0;
  int          wait_l = 0;

  int n_checks = 0, n_fail = 0;
  int hcycles = 0;

  always #(HCLK_PERIOD/2) hclk = ~hclk;
  always #(BUS_PERIOD/2) bus_clk = ~bus_clk;

  function automatic logic [7:0] rd_byte(input logic [15:0] a);
    return a[7:0] * 8'd7 + a[15:8] + 8'h1D;
  endfunction

  assign data_in = slave16 ? {rd_byte(io_addr + 16'd1), rd_byte(io_addr)}
                           : {8'hEE, rd_byte(io_addr)};

  isa_io_seq uut (
    .hclk_i(hclk), .bus_clk_i(bus_clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_wide_i(req_wide), .req_wdata_i(req_wdata),
    .done_o(done), .rdata_o(rdata), .err_o(err),
    .io_addr_o(io_addr), .ior_no(ior_n), .iow_no(iow_n), .bhe_no(bhe_n),
    .bus_data_o(bus_data), .data_oe_o(data_oe), .data_i(data_in),
    .chrdy_i(chrdy), .cs16_ni(~slave16)
  );

  // slave model and bus monitor
  logic [15:0] rec_addr [4];
  int          rec_len  [4];
  logic        rec_wr   [4], rec_bhe [4], rec_setup [4], rec_hold [4], rec_bad [4];
  logic [15:0] rec_wdata[4];
  int          rec_n = 0;
  logic        oe_seen = 0;
  logic        in_cyc = 0;
  logic [15:0] prev_addr = 0, cyc_addr = 0, cyc_wdata = 0;
  int          cyc_len = 0;
  logic        cyc_wr = 0, cyc_bhe = 0, cyc_setup = 0, cyc_bad = 0;

  always @(negedge bus_clk) begin
    if (data_oe) oe_seen = 1;
    if (!ior_n || !iow_n) begin
      if (!in_cyc) begin
        in_cyc    = 1;
        cyc_len   = 0;
        cyc_addr  = io_addr;
        cyc_setup = (prev_addr == io_addr);
        cyc_wr    = !iow_n;
        cyc_bhe   = !bhe_n;
        cyc_wdata = bus_data;
        cyc_bad   = 0;
      end
      cyc_len++;
      if (io_addr != cyc_addr || bus_data != cyc_wdata) cyc_bad = 1;
      if ((!ior_n && data_oe) || (!iow_n && !data_oe)) cyc_bad = 1;
      chrdy = (cyc_len - 1 >= wait_l);
    end else begin
      if (in_cyc) begin
        in_cyc = 0;
        if (rec_n < 4) begin
          rec_addr[rec_n]  = cyc_addr;
          rec_len[rec_n]   = cyc_len;
          rec_wr[rec_n]    = cyc_wr;
          rec_bhe[rec_n]   = cyc_bhe;
          rec_setup[rec_n] = cyc_setup;
          rec_hold[rec_n]  = (io_addr == cyc_addr);
          rec_bad[rec_n]   = cyc_bad;
          rec_wdata[rec_n] = cyc_wdata;
        end
        rec_n++;
      end
      chrdy = 1;
    end
    prev_addr = io_addr;
  end

  always @(posedge hclk) begin
    hcycles++;
    if (hcycles == 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=<150000", hcycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [15:0] a, input bit wr, input bit wide,
                         input logic [15:0] wd, input bit s16, input int wl,
                         input bit poke_busy);
    int   cmd, exp_len, exp_n, guard;
    bit   is16, exp_err;
    logic [15:0] got_rdata, exp_rdata;
    logic got_err;
    string ltag;
    slave16 = s16; wait_l = wl;
    @(negedge hclk);
    rec_n = 0; oe_seen = 0;
    check(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_addr = a; req_write = wr; req_wide = wide; req_wdata = wd; req_valid = 1;
    @(negedge hclk);
    req_valid = 0;
    if (poke_busy) begin
      check(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
      req_addr = a ^ 16'h0F0F; req_write = ~wr; req_wide = 0; req_valid = 1;
      repeat (3) @(negedge hclk);
      req_valid = 0;
    end
    guard = 0;
    while (!done && guard < 8000) begin @(negedge hclk); guard++; end
    check(done == 1'b1, "R9 done pulse", done, 1);
    got_rdata = rdata; got_err = err;
    repeat (2) @(negedge hclk);
    check(done == 1'b0, "R9 done single", done, 0);
    repeat (3) @(negedge bus_clk);

    is16    = wide && s16;
    cmd     = is16 ? CMD16 : CMD8;
    exp_err = (wl - cmd + 1) > TMO;
    exp_len = exp_err ? cmd + TMO : ((wl + 1 > cmd) ? wl + 1 : cmd);
    exp_n   = exp_err ? 1 : ((wide && !s16) ? 2 : 1);
    ltag    = exp_err ? "R6 timeout strobe length" :
              (wl >= cmd) ? "R3 stretched strobe length" :
              is16 ? "R2 word strobe length" : "R1 byte strobe length";

    check(rec_n == exp_n, wide ? "R4 cycle count" : "R5 cycle count", rec_n, exp_n);
    check(got_err == exp_err, "R6 err flag", got_err, exp_err);
    check(oe_seen == wr, "R7 data_oe only on writes", oe_seen, wr);
    for (int i = 0; i < exp_n && i < rec_n && i < 4; i++) begin
      check(rec_addr[i] == a + 16'(i), "R4 cycle address", rec_addr[i], a + 16'(i));
      check(rec_len[i] == exp_len, ltag, rec_len[i], exp_len);
      check(rec_setup[i] && rec_hold[i] && !rec_bad[i], "R8 address setup/hold/stable",
            {rec_setup[i], rec_hold[i], rec_bad[i]}, 3'b110);
      check(rec_wr[i] == wr, "R1 strobe kind", rec_wr[i], wr);
      check(rec_bhe[i] == (wide && i == 0), wide ? "R4 bhe" : "R5 bhe", rec_bhe[i], wide && i == 0);
      if (wr) begin
        if (is16)
          check(rec_wdata[i] == wd, "R2 word write lanes", rec_wdata[i], wd);
        else if (i == 0)
          check(rec_wdata[i][7:0] == wd[7:0], "R1 byte write lanes", rec_wdata[i][7:0], wd[7:0]);
        else
          check(rec_wdata[i][7:0] == wd[15:8], "R4 high byte swapped", rec_wdata[i][7:0], wd[15:8]);
      end
    end
    if (!wr && !exp_err) begin
      exp_rdata = wide ? {rd_byte(a + 16'd1), rd_byte(a)} : {8'h00, rd_byte(a)};
      check(got_rdata == exp_rdata, wide ? (s16 ? "R2 word read" : "R4 merged read") : "R5 byte read",
            got_rdata, exp_rdata);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge hclk);
    check(ior_n && iow_n, "R10 strobes idle in reset", {ior_n, iow_n}, 2'b11);
    check(!data_oe, "R10 oe low in reset", data_oe, 0);
    check(req_ready && !done, "R10 ready/done in reset", {req_ready, done}, 2'b10);
    rst_n = 1;
    repeat (3) @(negedge bus_clk);
    check(ior_n && iow_n && !data_oe, "R7 idle bus quiet", {ior_n, iow_n, data_oe}, 3'b110);

    // directed
    run_txn(16'h0300, 0, 0, 16'h0000, 0, 0, 0);   // R1 byte read
    run_txn(16'h0301, 1, 0, 16'hBEA5, 1, 0, 0);   // R5 byte write to 16-bit slave
    run_txn(16'h0320, 0, 1, 16'h0000, 1, 0, 0);   // R2 word read
    run_txn(16'h0322, 1, 1, 16'h1234, 1, 0, 1);   // R2 word write, R9 busy poke
    run_txn(16'h03F8, 0, 1, 16'h0000, 0, 0, 0);   // R4 split read
    run_txn(16'h03FE, 1, 1, 16'hC3D7, 0, 2, 1);   // R4 split write
    run_txn(16'h0200, 0, 0, 16'h0000, 0, CMD8 - 1, 0);  // R3 no stretch
    run_txn(16'h0202, 0, 0, 16'h0000, 0, CMD8, 0);      // R3 one wait
    run_txn(16'h0204, 1, 1, 16'h5A5A, 1, CMD16, 0);     // R3 word one wait
    run_txn(16'h0210, 0, 0, 16'h0000, 0, CMD8 + TMO - 1, 0); // R6 just under
    run_txn(16'h0212, 0, 0, 16'h0000, 0, CMD8 + TMO, 0);     // R6 timeout
    run_txn(16'h0214, 0, 1, 16'h0000, 0, CMD8 + TMO, 0);     // R6 split aborted
    run_txn(16'h0216, 1, 1, 16'hAAAA, 1, CMD16 + TMO, 0);    // R6 word timeout
    run_txn(16'h0218, 0, 1, 16'h0000, 1, 0, 0);              // recovery after timeout

    // random
    for (int k = 0; k < 40; k++) begin
      run_txn(16'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
              1'($urandom), int'($urandom_range(0, 6)), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule